// File: doc/BRIEF.md
# Pointer-Addressed Byte Store on a Two-Wire Bus

This block is a two-wire serial bus slave that gives a host access to a 128-byte on-chip store. The store is a register array that reset clears. The slave oversamples the clock and data lines with the system clock. It finds start and stop conditions, and it matches a 7-bit device address that is set by a parameter. The slave pulls data low to acknowledge and to send zeros. It never drives data high: the open-drain line is modelled as a drive-low enable.

An internal address pointer selects the byte. The pointer survives from one packet to the next. Four packet shapes are supported:

- A one-byte write packet loads the pointer.
- An address-only read packet returns the byte at the pointer and then steps the pointer.
- A two-byte write packet stores a data byte at a given address.
- An address write followed by a repeated start and a read returns one byte from a chosen address.

A write-protect input, active high, keeps the store unchanged. A write is still acknowledged while it is high.

Top module: `smb_ptr_mem`

## Requirements
- R1: After reset the slave drives nothing, every store byte reads 0x00, and the slave releases the data line after a stop (data rising while the clock is high). A start is data falling while the clock is high.
- R2: After a start the slave takes 8 bits, MSB first. These are a 7-bit device address followed by a direction bit (1 = read, 0 = write). When the address equals DEV_ADDR, the slave acknowledges by holding data low through the ninth clock.
- R3: When the device address does not match, the slave leaves the ninth bit high (NACK). It then ignores all bytes until the next start, and neither the pointer nor the store changes.
- R4: In a write packet, the first byte after the device address is loaded into the pointer, truncated to its low 7 bits. A packet that stops after this byte changes only the pointer.
- R5: In a read packet, the slave sends the byte at the pointer, MSB first, and the pointer then advances by one. The pointer wraps from 127 to 0.
- R6: In a write packet, a second byte after the pointer byte is stored at the pointer address. The pointer keeps that address afterwards.
- R7: A pointer byte followed by a repeated start and a read returns the byte at that address.
- R8: While write protect is high, the data byte of a write is still acknowledged, but the store keeps its old contents.
- R9: A third byte after the device address in a write packet is NACKed and is not stored.
- R10: In a read, a master ACK (0) after a byte makes the slave send the next byte from the advanced pointer. A master NACK (1) ends the transfer with the data line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| wpIn | input | 1 | Write protect, high blocks store updates |
| sdaDriveLow | output | 1 | Enable that pulls the data line low |

## Verification
Two situations are the hardest to reach from the pins: the pointer wrap at the top of the store, and the ignore state after a failed address match. The stimulus reaches the wrap by writing address 127, pointing there with a pointer-only packet, and then issuing two address-only reads. It reaches the ignore state by sending a wrong device address followed by bytes that would otherwise load the pointer and write the store. Plain reads then show that neither the pointer nor the store moved. A repeated-start read that the master keeps acknowledging checks that the pointer keeps stepping within one packet.

// File: rtl/smb_ptr_pkg.sv
package smb_ptr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } ctlState_t;

  // one-cycle commands from control to datapath
  typedef struct packed {
    logic sampleBit;  // shift the data level into the receive register
    logic ptrLoad;    // receive register -> pointer
    logic memWrite;   // receive register -> store[pointer]
    logic txLoad;     // store[pointer] -> transmit register, pointer + 1
    logic txShift;    // next transmit bit to the MSB
  } dpStrobe_t;

endpackage

// File: rtl/smb_ptr_sync.sv
module smb_ptr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLevel,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclLast;
  logic sdaLast;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclLast <= 1'b1;
      sdaLast <= 1'b1;
    end else begin
      sclLast <= sclPipe[STAGES-1];
      sdaLast <= sdaPipe[STAGES-1];
    end
  end

  assign sclLevel  = sclPipe[STAGES-1];
  assign sdaLevel  = sdaPipe[STAGES-1];
  assign sclRise   = sclLevel & ~sclLast;
  assign sclFall   = ~sclLevel & sclLast;
  assign startSeen = sclLevel & sclLast & sdaLast & ~sdaLevel;
  assign stopSeen  = sclLevel & sclLast & ~sdaLast & sdaLevel;

endmodule

// File: rtl/smb_ptr_ctrl.sv
module smb_ptr_ctrl
  import smb_ptr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startSeen,
  input  logic       stopSeen,
  input  logic       sdaLevel,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output dpStrobe_t  stb,
  output logic       sdaDriveLow
);

  ctlState_t  state, stateNext;
  logic [3:0] bitCnt, bitCntNext;
  logic [1:0] byteIdx, byteIdxNext;
  logic       isRead, isReadNext;
  logic       masterAck, masterAckNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      byteIdx   <= '0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state     <= stateNext;
      bitCnt    <= bitCntNext;
      byteIdx   <= byteIdxNext;
      isRead    <= isReadNext;
      masterAck <= masterAckNext;
    end
  end

  always_comb begin
    stb           = '0;
    stateNext     = state;
    bitCntNext    = bitCnt;
    byteIdxNext   = byteIdx;
    isReadNext    = isRead;
    masterAckNext = masterAck;
    if (stopSeen) begin
      stateNext = ST_IDLE;
    end else if (startSeen) begin
      stateNext   = ST_RX;
      bitCntNext  = '0;
      byteIdxNext = '0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (sclRise && bitCnt < 4'd8) begin
            stb.sampleBit = 1'b1;
            bitCntNext    = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            unique case (byteIdx)
              2'd0: begin
                if (rxByte[7:1] == DEV_ADDR) begin
                  stateNext  = ST_RXACK;
                  isReadNext = rxByte[0];
                end else begin
                  stateNext = ST_IDLE;
                end
              end
              2'd1: begin
                stb.ptrLoad = 1'b1;
                stateNext   = ST_RXACK;
              end
              2'd2: begin
                stb.memWrite = 1'b1;
                stateNext    = ST_RXACK;
              end
              default: stateNext = ST_IDLE;
            endcase
          end
        end
        ST_RXACK: begin
          if (sclFall) begin
            bitCntNext = '0;
            if (isRead) begin
              stb.txLoad = 1'b1;
              stateNext  = ST_TX;
            end else begin
              stateNext   = ST_RX;
              byteIdxNext = (byteIdx == 2'd3) ? 2'd3 : byteIdx + 2'd1;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stateNext  = ST_TXACK;
              bitCntNext = '0;
            end else begin
              stb.txShift = 1'b1;
              bitCntNext  = bitCnt + 4'd1;
            end
          end
        end
        ST_TXACK: begin
          if (sclRise) begin
            masterAckNext = ~sdaLevel;
          end else if (sclFall) begin
            if (masterAck) begin
              stb.txLoad = 1'b1;
              stateNext  = ST_TX;
            end else begin
              stateNext = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaDriveLow = (state == ST_RXACK) | ((state == ST_TX) & ~txMsb);

endmodule

// File: rtl/smb_ptr_dp.sv
module smb_ptr_dp
  import smb_ptr_pkg::*;
#(
  parameter int MEM_BYTES = 128,
  parameter int PTR_W     = $clog2(MEM_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdaLevel,
  input  logic             wpIn,
  input  dpStrobe_t        stb,
  output logic [7:0]       rxByte,
  output logic             txMsb,
  output logic [PTR_W-1:0] ptrVal
);

  logic [7:0]       store [MEM_BYTES];
  logic [7:0]       rxShift;
  logic [7:0]       txReg;
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txReg   <= '0;
      ptr     <= '0;
      for (int i = 0; i < MEM_BYTES; i++) store[i] <= '0;
    end else begin
      if (stb.sampleBit) rxShift <= {rxShift[6:0], sdaLevel};
      if (stb.ptrLoad) ptr <= rxShift[PTR_W-1:0];
      if (stb.memWrite && !wpIn) store[ptr] <= rxShift;
      if (stb.txLoad) begin
        txReg <= store[ptr];
        ptr   <= ptr + 1'b1;
      end else if (stb.txShift) begin
        txReg <= {txReg[6:0], 1'b0};
      end
    end
  end

  assign rxByte = rxShift;
  assign txMsb  = txReg[7];
  assign ptrVal = ptr;

endmodule

// File: rtl/smb_ptr_mem.sv
module smb_ptr_mem
  import smb_ptr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         MEM_BYTES   = 128,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic wpIn,
  output logic sdaDriveLow
);

  localparam int PTR_W = $clog2(MEM_BYTES);

  logic             sclLevel, sdaLevel, sclRise, sclFall, startSeen, stopSeen;
  dpStrobe_t        stb;
  logic [7:0]       rxByte;
  logic             txMsb;
  logic [PTR_W-1:0] ptrVal;

  smb_ptr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLevel(sclLevel), .sdaLevel(sdaLevel), .sclRise(sclRise),
    .sclFall(sclFall), .startSeen(startSeen), .stopSeen(stopSeen)
  );

  smb_ptr_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaLevel(sdaLevel),
    .rxByte(rxByte), .txMsb(txMsb), .stb(stb), .sdaDriveLow(sdaDriveLow)
  );

  smb_ptr_dp #(.MEM_BYTES(MEM_BYTES), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .sdaLevel(sdaLevel), .wpIn(wpIn), .stb(stb),
    .rxByte(rxByte), .txMsb(txMsb), .ptrVal(ptrVal)
  );

endmodule

// File: rtl/smb_ptr_mem_chk.sv
module smb_ptr_mem_chk
  import smb_ptr_pkg::*;
#(
  parameter int PTR_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclLevel,
  input logic             stopSeen,
  input logic             sdaDriveLow,
  input dpStrobe_t        stb,
  input logic [7:0]       rxByte,
  input logic [PTR_W-1:0] ptrVal
);

  // R1: the slave only changes its drive while the clock is low
  p_drive_steady_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sclLevel && $past(sclLevel)) |-> $stable(sdaDriveLow));

  // R1: a stop leaves the line released
  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaDriveLow);

  // R4: the pointer takes the low bits of the received byte
  p_ptr_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.ptrLoad |=> (ptrVal == $past(rxByte[PTR_W-1:0])));

  // R5: each fetched byte steps the pointer by one
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.txLoad |=> (ptrVal == PTR_W'($past(ptrVal) + 1'b1)));

  // R6: a store write leaves the pointer in place
  p_write_keeps_ptr_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.memWrite |=> $stable(ptrVal));

  // R6: at most one datapath command per cycle
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.sampleBit, stb.ptrLoad, stb.memWrite, stb.txLoad, stb.txShift}));

endmodule

bind smb_ptr_mem smb_ptr_mem_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclLevel(sclLevel), .stopSeen(stopSeen),
  .sdaDriveLow(sdaDriveLow), .stb(stb), .rxByte(rxByte), .ptrVal(ptrVal)
);

// File: tb/smb_ptr_mem_bench.sv
module smb_ptr_mem_bench;

  localparam logic [6:0] DEV = 7'h50;
  localparam int Q = 10;
  localparam int NVEC = 14;
  // op: 0 write byte, 1 read byte, 2 pointer only, 3 receive byte
  // fields: op[26:25] wp[24] addr[23:16] data[15:8] expect[7:0]
  localparam logic [26:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 8'h05, 8'hA5, 8'h00},
    {2'd1, 1'b0, 8'h05, 8'h00, 8'hA5},
    {2'd0, 1'b0, 8'h7F, 8'h3C, 8'h00},
    {2'd2, 1'b0, 8'h7F, 8'h00, 8'h00},
    {2'd3, 1'b0, 8'h00, 8'h00, 8'h3C},
    {2'd3, 1'b0, 8'h00, 8'h00, 8'h00},
    {2'd0, 1'b1, 8'h06, 8'h11, 8'h00},
    {2'd1, 1'b0, 8'h06, 8'h00, 8'h00},
    {2'd0, 1'b0, 8'h85, 8'h77, 8'h00},
    {2'd1, 1'b0, 8'h05, 8'h00, 8'h77},
    {2'd2, 1'b0, 8'h04, 8'h00, 8'h00},
    {2'd3, 1'b0, 8'h00, 8'h00, 8'h00},
    {2'd3, 1'b0, 8'h00, 8'h00, 8'h77},
    {2'd3, 1'b0, 8'h00, 8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic wp = 1'b0;
  logic sdaDriveLow;
  logic sdaLine;
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign sdaLine = sdaM & ~sdaDriveLow;

  smb_ptr_mem #(.DEV_ADDR(DEV)) u_smb_ptr_mem (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .wpIn(wp), .sdaDriveLow(sdaDriveLow)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; hold(); sclM = 1'b1; hold(); sdaM = 1'b0; hold(); sclM = 1'b0; hold();
  endtask

  task automatic busStop();
    sdaM = 1'b0; hold(); sclM = 1'b1; hold(); sdaM = 1'b1; hold();
  endtask

  task automatic putBit(input logic b);
    sdaM = b; hold(); sclM = 1'b1; hold(); hold(); sclM = 1'b0; hold();
  endtask

  task automatic getBit(output logic b);
    sdaM = 1'b1; hold(); sclM = 1'b1; hold(); b = sdaLine; hold(); sclM = 1'b0; hold();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic nak);
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(nak);
  endtask

  task automatic recvByte(output logic [7:0] v, input logic nak);
    for (int i = 7; i >= 0; i--) getBit(v[i]);
    putBit(nak);
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [7:0] d, output logic [2:0] naks);
    busStart();
    sendByte({DEV, 1'b0}, naks[2]);
    sendByte(a, naks[1]);
    sendByte(d, naks[0]);
    busStop();
  endtask

  task automatic doRead(input logic [7:0] a, output logic [7:0] d, output logic [2:0] naks);
    busStart();
    sendByte({DEV, 1'b0}, naks[2]);
    sendByte(a, naks[1]);
    busStart();
    sendByte({DEV, 1'b1}, naks[0]);
    recvByte(d, 1'b1);
    busStop();
  endtask

  task automatic doPoint(input logic [7:0] a, output logic [2:0] naks);
    busStart();
    sendByte({DEV, 1'b0}, naks[2]);
    sendByte(a, naks[1]);
    naks[0] = 1'b0;
    busStop();
  endtask

  task automatic doRecv(output logic [7:0] d, output logic [2:0] naks);
    busStart();
    sendByte({DEV, 1'b1}, naks[2]);
    naks[1:0] = 2'b00;
    recvByte(d, 1'b1);
    busStop();
  endtask

  function automatic string tagFor(input logic [1:0] op, input logic wpv);
    if (wpv) return "R8";
    case (op)
      2'd0: return "R6";
      2'd1: return "R7";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [2:0] naks;
    logic [7:0] got;
    logic n0, n1, n2;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    check("R1 drive after reset", {7'b0, sdaDriveLow}, 8'h00);
    doRead(8'h40, got, naks);
    check("R1 cleared byte", got, 8'h00);
    check("R2 acks", {5'b0, naks}, 8'h00);

    // table of packets
    for (int k = 0; k < NVEC; k++) begin
      logic [1:0] op;
      op = VEC[k][26:25];
      wp = VEC[k][24];
      got = 8'h00;
      case (op)
        2'd0: doWrite(VEC[k][23:16], VEC[k][15:8], naks);
        2'd1: doRead(VEC[k][23:16], got, naks);
        2'd2: doPoint(VEC[k][23:16], naks);
        default: doRecv(got, naks);
      endcase
      wp = 1'b0;
      check({"R2 acks ", tagFor(op, VEC[k][24])}, {5'b0, naks}, 8'h00);
      if (op == 2'd1 || op == 2'd3) check(tagFor(op, 1'b0), got, VEC[k][7:0]);
    end
    // pointer is now 7

    // R3: wrong address is NACKed and the rest of the packet is ignored
    busStart();
    sendByte({DEV ^ 7'h01, 1'b0}, n0);
    sendByte(8'h05, n1);
    sendByte(8'h99, n2);
    busStop();
    check("R3 nacks", {5'b0, n0, n1, n2}, 8'h07);
    doRecv(got, naks);
    check("R3 pointer kept", got, 8'h00);
    doRead(8'h05, got, naks);
    check("R3 store kept", got, 8'h77);

    // R6: pointer stays on the written address
    doWrite(8'h20, 8'h5A, naks);
    doRecv(got, naks);
    check("R6 pointer after write", got, 8'h5A);

    // R9: third write byte is NACKed and not stored
    busStart();
    sendByte({DEV, 1'b0}, n0);
    sendByte(8'h10, n1);
    sendByte(8'h22, n2);
    check("R9 first bytes acked", {6'b0, n1, n2}, 8'h00);
    sendByte(8'h33, n0);
    busStop();
    check("R9 extra byte nack", {7'b0, n0}, 8'h01);
    doRead(8'h10, got, naks);
    check("R9 stored byte", got, 8'h22);
    doRead(8'h11, got, naks);
    check("R9 next byte untouched", got, 8'h00);

    // R10: master ACK continues, NACK ends
    busStart();
    sendByte({DEV, 1'b0}, n0);
    sendByte(8'h04, n1);
    busStart();
    sendByte({DEV, 1'b1}, n2);
    recvByte(got, 1'b0);
    check("R10 byte 4", got, 8'h00);
    recvByte(got, 1'b0);
    check("R10 byte 5", got, 8'h77);
    recvByte(got, 1'b1);
    check("R10 byte 6", got, 8'h00);
    check("R10 released after nack", {7'b0, sdaDriveLow}, 8'h00);
    busStop();
    check("R1 released after stop", {7'b0, sdaDriveLow}, 8'h00);

    // R8: protected write is acked and leaves the old value
    wp = 1'b1;
    doWrite(8'h05, 8'hEE, naks);
    wp = 1'b0;
    check("R8 acked", {5'b0, naks}, 8'h00);
    doRead(8'h05, got, naks);
    check("R8 value held", got, 8'h77);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule